// File: doc/BRIEF.md
# MD5 Block Compression Engine

The engine applies the MD5 compression function to one 512-bit message block. It starts from a 128-bit chaining value and returns the updated chaining value. The caller provides blocks that are already padded. To hash a longer message, the caller feeds each block in turn and passes back the previous digest as the next seed. The engine does no padding, appends no length and sequences no blocks on its own.

The engine performs one of the 64 rounds per clock. Each round adds four terms: a message word, a round constant, the word being replaced and the nonlinear mix of the other three words. The engine sums the message word, the constant and the replaced word for the next round while the current round is still running. When the next round begins, only the nonlinear mix and the rotate remain on the loop from state to state. After the last round there is one more cycle. In that cycle the four working words are added to the seed, the digest register is loaded and a one-cycle done pulse is raised.

Top module: `md5_block_engine`

## Requirements
- R1: While reset is low, and after it is released until the first job completes, `busy_o` and `done_o` are 0 and `digest_o` is all zeros.
- R2: A high `start_i` sampled while `busy_o` is 0 starts a job. This includes the cycle in which `done_o` is high. `busy_o` is high for the next 65 cycles. `done_o` rises on the 65th rising edge after the edge that sampled `start_i`, and stays high for exactly one cycle, during which `busy_o` is 0.
- R3: For the padded empty message (byte 0 = 0x80, all other bytes 0) with the standard MD5 initial value as seed, the digest is the MD5 of the empty string.
- R4: Message word k occupies `block_i[32k+31:32k]`, and each word is little-endian: message byte n lies at bits `[8n+7:8n]`. The padded block of "abc" therefore yields the MD5 of "abc".
- R5: A `start_i` pulse while `busy_o` is 1 is ignored. This holds in the final fold cycle too. The running job keeps its 65-cycle length and its digest, and no new job follows.
- R6: `digest_o` changes only on the edge that raises `done_o`. Between jobs it holds its value whatever `block_i` and `seed_i` do.
- R7: Seed and digest share one layout: word A in bits [31:0], then B, C and D. Each digest word is the seed word plus the final working word, mod 2^32. Feeding a digest back as the seed of the next block therefore chains a multi-block message, and its final digest equals the MD5 of the whole message.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start request, accepted while idle |
| block_i | input | 512 | Padded message block, word 0 in bits [31:0] |
| seed_i | input | 128 | Incoming chaining value, word A in bits [31:0] |
| busy_o | output | 1 | High while a block is being compressed |
| done_o | output | 1 | One-cycle completion pulse |
| digest_o | output | 128 | Outgoing chaining value, held between jobs |

## Verification
The checker assumes that every job begins from an idle engine. It relies on this to restart its own length counter when `start_i` meets a low `busy_o`. A start seen while busy must leave that counter running, so a completion pulse that comes at any count other than 65 points to a restart or a skipped round. The bench drives `start_i` and `block_i` only on falling edges. It deliberately places an extra start pulse in the middle of the run and in the fold cycle, and it changes the block inputs during that run, so the stimulus reaches the ignore and hold rules without breaking the idle-start assumption. Because the digests of known messages are compared, the round constants, rotate amounts, word schedule and byte order are all checked at the ports.

// File: rtl/md5_pkg.sv
package md5_pkg;
    localparam int WORD_W    = 32;
    localparam int BLK_WORDS = 16;
    localparam int STATE_W   = 4;
    localparam int STEPS     = 64;
    localparam int CNT_W     = $clog2(STEPS);
    localparam int BLK_W     = WORD_W * BLK_WORDS;
    localparam int SEED_W    = WORD_W * STATE_W;
    localparam int SEL_W     = $clog2(BLK_WORDS);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [CNT_W-1:0]  step_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_FOLD = 2'd2
    } phase_e;

    function automatic word_t round_const(input step_t i);
        word_t k;
        case (i)
            6'd0:  k = 32'hd76aa478; 6'd1:  k = 32'he8c7b756; 6'd2:  k = 32'h242070db; 6'd3:  k = 32'hc1bdceee;
            6'd4:  k = 32'hf57c0faf; 6'd5:  k = 32'h4787c62a; 6'd6:  k = 32'ha8304613; 6'd7:  k = 32'hfd469501;
            6'd8:  k = 32'h698098d8; 6'd9:  k = 32'h8b44f7af; 6'd10: k = 32'hffff5bb1; 6'd11: k = 32'h895cd7be;
            6'd12: k = 32'h6b901122; 6'd13: k = 32'hfd987193; 6'd14: k = 32'ha679438e; 6'd15: k = 32'h49b40821;
            6'd16: k = 32'hf61e2562; 6'd17: k = 32'hc040b340; 6'd18: k = 32'h265e5a51; 6'd19: k = 32'he9b6c7aa;
            6'd20: k = 32'hd62f105d; 6'd21: k = 32'h02441453; 6'd22: k = 32'hd8a1e681; 6'd23: k = 32'he7d3fbc8;
            6'd24: k = 32'h21e1cde6; 6'd25: k = 32'hc33707d6; 6'd26: k = 32'hf4d50d87; 6'd27: k = 32'h455a14ed;
            6'd28: k = 32'ha9e3e905; 6'd29: k = 32'hfcefa3f8; 6'd30: k = 32'h676f02d9; 6'd31: k = 32'h8d2a4c8a;
            6'd32: k = 32'hfffa3942; 6'd33: k = 32'h8771f681; 6'd34: k = 32'h6d9d6122; 6'd35: k = 32'hfde5380c;
            6'd36: k = 32'ha4beea44; 6'd37: k = 32'h4bdecfa9; 6'd38: k = 32'hf6bb4b60; 6'd39: k = 32'hbebfbc70;
            6'd40: k = 32'h289b7ec6; 6'd41: k = 32'heaa127fa; 6'd42: k = 32'hd4ef3085; 6'd43: k = 32'h04881d05;
            6'd44: k = 32'hd9d4d039; 6'd45: k = 32'he6db99e5; 6'd46: k = 32'h1fa27cf8; 6'd47: k = 32'hc4ac5665;
            6'd48: k = 32'hf4292244; 6'd49: k = 32'h432aff97; 6'd50: k = 32'hab9423a7; 6'd51: k = 32'hfc93a039;
            6'd52: k = 32'h655b59c3; 6'd53: k = 32'h8f0ccc92; 6'd54: k = 32'hffeff47d; 6'd55: k = 32'h85845dd1;
            6'd56: k = 32'h6fa87e4f; 6'd57: k = 32'hfe2ce6e0; 6'd58: k = 32'ha3014314; 6'd59: k = 32'h4e0811a1;
            6'd60: k = 32'hf7537e82; 6'd61: k = 32'hbd3af235; 6'd62: k = 32'h2ad7d2bb; 6'd63: k = 32'heb86d391;
            default: k = '0;
        endcase
        return k;
    endfunction

    // rotate amount: one set of four per round, picked by position in the group
    function automatic logic [4:0] rot_amount(input step_t i);
        logic [4:0] s;
        case ({i[5:4], i[1:0]})
            4'h0: s = 5'd7;  4'h1: s = 5'd12; 4'h2: s = 5'd17; 4'h3: s = 5'd22;
            4'h4: s = 5'd5;  4'h5: s = 5'd9;  4'h6: s = 5'd14; 4'h7: s = 5'd20;
            4'h8: s = 5'd4;  4'h9: s = 5'd11; 4'hA: s = 5'd16; 4'hB: s = 5'd23;
            4'hC: s = 5'd6;  4'hD: s = 5'd10; 4'hE: s = 5'd15; default: s = 5'd21;
        endcase
        return s;
    endfunction

    // message word schedule per round
    function automatic logic [SEL_W-1:0] word_sel(input step_t i);
        logic [SEL_W-1:0] j;
        logic [SEL_W-1:0] w;
        j = i[SEL_W-1:0];
        case (i[5:4])
            2'd0:    w = j;
            2'd1:    w = j * 4'd5 + 4'd1;
            2'd2:    w = j * 4'd3 + 4'd5;
            default: w = j * 4'd7;
        endcase
        return w;
    endfunction

    function automatic word_t mix_fn(input logic [1:0] rnd, input word_t x, input word_t y, input word_t z);
        word_t f;
        case (rnd)
            2'd0:    f = (x & y) | (~x & z);
            2'd1:    f = (x & z) | (y & ~z);
            2'd2:    f = x ^ y ^ z;
            default: f = y ^ (x | ~z);
        endcase
        return f;
    endfunction

    function automatic word_t rotl(input word_t v, input logic [4:0] s);
        return (v << s) | (v >> (6'd32 - {1'b0, s}));
    endfunction
endpackage

// File: rtl/md5_presum.sv
// Early sum for a round: message word + constant + word being replaced.
module md5_presum
    import md5_pkg::*;
(
    input  logic [BLK_W-1:0] blk,
    input  step_t            idx,
    input  word_t            target,
    output word_t            pre
);
    word_t words [BLK_WORDS];

    for (genvar g = 0; g < BLK_WORDS; g++) begin : g_split
        assign words[g] = blk[g*WORD_W +: WORD_W];
    end

    word_t xk_plus_t;
    always_comb begin
        xk_plus_t = words[word_sel(idx)] + round_const(idx);
        pre       = xk_plus_t + target;
    end
endmodule

// File: rtl/md5_step.sv
// Late part of a round: only the mix, the rotate and the final add wait on state.
module md5_step
    import md5_pkg::*;
(
    input  step_t idx,
    input  word_t pre,
    input  word_t b,
    input  word_t c,
    input  word_t d,
    output word_t new_b
);
    word_t sum;
    always_comb begin
        sum   = pre + mix_fn(idx[5:4], b, c, d);
        new_b = b + rotl(sum, rot_amount(idx));
    end
endmodule

// File: rtl/md5_fold.sv
// Word-wise add of final working words onto the seed.
module md5_fold
    import md5_pkg::*;
(
    input  logic [SEED_W-1:0] seed,
    input  logic [SEED_W-1:0] work,
    output logic [SEED_W-1:0] result
);
    for (genvar g = 0; g < STATE_W; g++) begin : g_add
        assign result[g*WORD_W +: WORD_W] = seed[g*WORD_W +: WORD_W] + work[g*WORD_W +: WORD_W];
    end
endmodule

// File: rtl/md5_block_engine.sv
module md5_block_engine
    import md5_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [BLK_W-1:0]  block_i,
    input  logic [SEED_W-1:0] seed_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [SEED_W-1:0] digest_o
);
    typedef struct packed {
        phase_e            phase;
        step_t             cnt;
        word_t             a;
        word_t             b;
        word_t             c;
        word_t             d;
        word_t             pre;
        logic [SEED_W-1:0] seed;
        logic [BLK_W-1:0]  blk;
        logic [SEED_W-1:0] digest;
        logic              done;
    } eng_t;

    eng_t st_q, st_d;

    logic              run;
    step_t             ps_idx;
    logic [BLK_W-1:0]  ps_blk;
    word_t             ps_tgt;
    word_t             ps_pre;
    word_t             step_b;
    logic [SEED_W-1:0] fold_res;

    assign run    = (st_q.phase == PH_RUN);
    assign ps_idx = run ? st_q.cnt + 1'b1 : '0;
    assign ps_blk = run ? st_q.blk : block_i;
    assign ps_tgt = run ? st_q.d : seed_i[WORD_W-1:0];

    md5_presum u_presum (
        .blk    (ps_blk),
        .idx    (ps_idx),
        .target (ps_tgt),
        .pre    (ps_pre)
    );

    md5_step u_step (
        .idx   (st_q.cnt),
        .pre   (st_q.pre),
        .b     (st_q.b),
        .c     (st_q.c),
        .d     (st_q.d),
        .new_b (step_b)
    );

    md5_fold u_fold (
        .seed   (st_q.seed),
        .work   ({st_q.d, st_q.c, st_q.b, st_q.a}),
        .result (fold_res)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.phase = PH_RUN;
                    st_d.cnt   = '0;
                    st_d.blk   = block_i;
                    st_d.seed  = seed_i;
                    st_d.a     = seed_i[0*WORD_W +: WORD_W];
                    st_d.b     = seed_i[1*WORD_W +: WORD_W];
                    st_d.c     = seed_i[2*WORD_W +: WORD_W];
                    st_d.d     = seed_i[3*WORD_W +: WORD_W];
                    st_d.pre   = ps_pre;
                end
            end
            PH_RUN: begin
                st_d.a   = st_q.d;
                st_d.b   = step_b;
                st_d.c   = st_q.b;
                st_d.d   = st_q.c;
                st_d.pre = ps_pre;
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt == step_t'(STEPS - 1)) begin
                    st_d.phase = PH_FOLD;
                end
            end
            PH_FOLD: begin
                st_d.digest = fold_res;
                st_d.done   = 1'b1;
                st_d.phase  = PH_IDLE;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o   = (st_q.phase != PH_IDLE);
    assign done_o   = st_q.done;
    assign digest_o = st_q.digest;
endmodule

// File: rtl/md5_block_engine_chk.sv
module md5_block_engine_chk
    import md5_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [SEED_W-1:0] digest
);
    localparam int JOB_LEN = STEPS + 1;
    localparam int LEN_W   = $clog2(JOB_LEN + 1);

    logic [LEN_W-1:0] run_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (start && !busy) begin
            run_len <= '0;
        end else if (busy) begin
            run_len <= run_len + 1'b1;
        end
    end

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);                                        // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                   // R2
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));                                  // R2
    AST_JOB_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_len == LEN_W'(JOB_LEN)));                            // R5
    AST_DIGEST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(digest));                                        // R6
endmodule

bind md5_block_engine md5_block_engine_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start_i),
    .busy   (busy_o),
    .done   (done_o),
    .digest (digest_o)
);

// File: tb/md5_block_engine_test.sv
`timescale 1ns/1ps
module md5_block_engine_test;
    localparam logic [127:0] IV      = 128'h10325476_98badcfe_efcdab89_67452301;
    localparam logic [127:0] H_EMPTY = 128'h7e42f8ec980980e904b2008fd98c1dd4;
    localparam logic [127:0] H_ABC   = 128'h727fe1287d3f96d6b04fd23c98500190;
    localparam logic [127:0] H_DIGIT = 128'h7ab607212eda49ac55c9e32ba2f4ed57;
    localparam int           LAT     = 66;   // negedges from start drive to done

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [511:0] block_i = '0;
    logic [127:0] seed_i = '0;
    logic         busy_o;
    logic         done_o;
    logic [127:0] digest_o;

    int errors = 0;
    int checks = 0;
    logic [7:0] msg [128];

    always #2.5 clk = ~clk;

    md5_block_engine uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .block_i  (block_i),
        .seed_i   (seed_i),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .digest_o (digest_o)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic build(input string s, output int nblk);
        logic [63:0] bits;
        int len;
        len = s.len();
        for (int i = 0; i < 128; i++) msg[i] = 8'h00;
        for (int i = 0; i < len; i++) msg[i] = s[i];
        msg[len] = 8'h80;
        nblk = (len + 8) / 64 + 1;
        bits = 64'(len) * 64'd8;
        for (int k = 0; k < 8; k++) msg[64*nblk - 8 + k] = bits[8*k +: 8];
    endtask

    function automatic logic [511:0] get_block(input int j);
        logic [511:0] b;
        for (int n = 0; n < 64; n++) b[8*n +: 8] = msg[64*j + n];
        return b;
    endfunction

    // Called at a negedge; returns at the negedge where done is seen.
    task automatic run_block(input logic [511:0] blk, input logic [127:0] seed,
                             input bit intrude, output logic [127:0] dig, output int lat);
        start_i = 1'b1;
        block_i = blk;
        seed_i  = seed;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
            start_i = intrude && (lat == 10 || lat == 65);
            if (intrude) begin
                block_i = ~blk;
                seed_i  = ~seed;
            end
        end while (!done_o && lat < 200);
        start_i = 1'b0;
        dig = digest_o;
    endtask

    task automatic t_reset;
        check("R1 busy in reset", 128'(busy_o), 128'd0);
        check("R1 done in reset", 128'(done_o), 128'd0);
        check("R1 digest in reset", digest_o, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 busy after reset", 128'(busy_o), 128'd0);
    endtask

    task automatic t_empty;
        int nb, lat;
        logic [127:0] dig;
        build("", nb);
        check("R3 empty block count", 128'(nb), 128'd1);
        run_block(get_block(0), IV, 1'b0, dig, lat);
        check("R3 empty digest", dig, H_EMPTY);
        check("R2 latency", 128'(lat), 128'(LAT));
        check("R2 idle in done cycle", 128'(busy_o), 128'd0);
        @(negedge clk);
        check("R2 done one cycle", 128'(done_o), 128'd0);
    endtask

    task automatic t_abc_hold;
        int nb, lat;
        logic [127:0] dig;
        build("abc", nb);
        run_block(get_block(0), IV, 1'b0, dig, lat);
        check("R4 abc digest", dig, H_ABC);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            block_i = {16{32'hdeadbeef}} ^ 512'(i);
            seed_i  = {4{32'h5a5a0000}} ^ 128'(i);
        end
        check("R6 digest held", digest_o, H_ABC);
        check("R6 stays idle", 128'(busy_o), 128'd0);
    endtask

    task automatic t_ignore;
        int nb, lat;
        logic [127:0] dig;
        build("abc", nb);
        run_block(get_block(0), IV, 1'b1, dig, lat);
        check("R5 digest with stray starts", dig, H_ABC);
        check("R5 latency with stray starts", 128'(lat), 128'(LAT));
        @(negedge clk);
        check("R5 no restart after done", 128'(busy_o), 128'd0);
    endtask

    task automatic t_chain;
        int nb, lat;
        logic [127:0] d0, d1;
        build("12345678901234567890123456789012345678901234567890123456789012345678901234567890", nb);
        check("R7 block count", 128'(nb), 128'd2);
        run_block(get_block(0), IV, 1'b0, d0, lat);
        run_block(get_block(1), d0, 1'b0, d1, lat);   // started in the done cycle
        check("R2 start in done cycle latency", 128'(lat), 128'(LAT));
        check("R7 chained digest", d1, H_DIGIT);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_empty();
        t_abc_hold();
        t_ignore();
        t_chain();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule